// File: doc/BRIEF.md
# Shadow-Set Interrupt Acceptance Unit

This unit sits in a processor core between an external interrupt controller and the pipeline. Each cycle it decides whether the one presented request is taken. A request carries a level, a target shadow register set, a handler address and a nonmaskable flag. The unit compares the request with the current status word. That word holds a global enable, the running level, the register set in use and a flag that allows preemption inside the same register set.

When a request is taken, the unit copies the status word into a one-deep saved-status register. It then clears the enable, installs the new level and switches to the requested register set. An accept pulse with the chosen set and handler address follows one cycle later. Synchronous noninterrupt exceptions always go to register set 0. An exception-return input puts the saved word back in one cycle. Software can rewrite the enable and the same-set preemption flag through a small write port.

Top module: `shadow_irq_gate`

## Requirements
- R1: After a synchronous reset the enable, level, register set and preemption flag all read 0, the saved word is 0, and neither accept pulse is high.
- R2: A maskable request is never taken while the preemption flag is 0 and the request's target set equals the current set, whatever its level.
- R3: With the preemption flag at 1, a maskable request for the current set is taken when its level is strictly above the current level, and refused when it is equal or lower.
- R4: A maskable request for a different set is taken when the enable is 1 and its level is strictly above the current level.
- R5: A maskable request is refused when the enable is 0, and a maskable request with level 0 is always treated as absent.
- R6: On acceptance of an interrupt, the next cycle shows `acc_irq` at 1 and `acc_set`/`acc_addr` equal to the request's set and handler address. In the same cycle the enable reads 0, the level equals the request level and the current set equals the request set. The two pulses are never high together.
- R7: A request with the nonmaskable flag set is taken regardless of enable, level or target set, and wins over a simultaneous noninterrupt exception.
- R8: Every acceptance, of an interrupt or of an exception, copies the previous status word (enable, level, set, preemption flag) into the saved-status outputs.
- R9: `eret` has priority over everything else in its cycle. One cycle later it restores all four status fields from the saved word and raises no pulse.
- R10: A noninterrupt exception raises `acc_exc` one cycle later, with `acc_set` = 0 and `acc_addr` = EXC_ADDR (default 0x20). It switches the current set to 0, clears the enable, keeps the level, and wins over a simultaneous maskable request.
- R11: With no eret, no request taken and no exception, `sw_wr` loads `sw_ie` into the enable and `sw_pre` into the preemption flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Controller presents a request |
| req_nmi | input | 1 | Request is nonmaskable |
| req_lvl | input | 6 | Requested level |
| req_set | input | 6 | Target shadow register set |
| req_addr | input | ADDR_W | Handler address |
| exc_valid | input | 1 | Noninterrupt exception raised |
| eret | input | 1 | Return from exception |
| sw_wr | input | 1 | Software status write strobe |
| sw_ie | input | 1 | Enable value to write |
| sw_pre | input | 1 | Same-set preemption value to write |
| acc_irq | output | 1 | Interrupt taken (registered pulse) |
| acc_exc | output | 1 | Exception taken (registered pulse) |
| acc_set | output | 6 | Register set of the last acceptance |
| acc_addr | output | ADDR_W | Handler address of the last acceptance |
| cur_ie | output | 1 | Current global enable |
| cur_lvl | output | 6 | Current level |
| cur_set | output | 6 | Current register set |
| cur_pre | output | 1 | Current same-set preemption flag |
| sav_ie | output | 1 | Saved enable |
| sav_lvl | output | 6 | Saved level |
| sav_set | output | 6 | Saved register set |
| sav_pre | output | 1 | Saved preemption flag |

## Verification
Every result of this unit is due exactly one rising edge after the inputs that cause it are sampled. This covers the accept pulses, the chosen set and address, the new status word, the saved copy and the restore after `eret`. The bench drives each stimulus at a falling edge and lets one rising edge pass. It compares every output at the next falling edge against a status model that it steps with the same inputs. Each check carries the tag of the path the model took: same-set refusal, level refusal, nonmaskable, exception, return or software write.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int LVL_W = 6;
  localparam int SET_W = 6;

  typedef struct packed {
    logic             ie;
    logic [LVL_W-1:0] lvl;
    logic [SET_W-1:0] rset;
    logic             pre;
  } stat_t;
endpackage

// File: rtl/shirq_decide.sv
module shirq_decide
  import shirq_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] EXC_ADDR = 'h20
) (
  input  stat_t             cur,
  input  stat_t             sav,
  input  logic              eret,
  input  logic              req_valid,
  input  logic              req_nmi,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [SET_W-1:0]  req_set,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              exc_valid,
  input  logic              sw_wr,
  input  logic              sw_ie,
  input  logic              sw_pre,
  output stat_t             cur_n,
  output stat_t             sav_n,
  output logic              take_irq,
  output logic              take_exc,
  output logic [SET_W-1:0]  take_set,
  output logic [ADDR_W-1:0] take_addr
);
  logic nmi_ok, lvl_ok, set_ok, mask_ok;

  always_comb begin
    nmi_ok  = req_valid && req_nmi;
    lvl_ok  = (req_lvl != '0) && (req_lvl > cur.lvl);
    set_ok  = (req_set != cur.rset) || cur.pre;
    mask_ok = req_valid && !req_nmi && cur.ie && lvl_ok && set_ok;
  end

  always_comb begin
    cur_n     = cur;
    sav_n     = sav;
    take_irq  = 1'b0;
    take_exc  = 1'b0;
    take_set  = req_set;
    take_addr = req_addr;
    if (eret) begin
      cur_n = sav;
    end else if (nmi_ok) begin
      sav_n      = cur;
      cur_n.ie   = 1'b0;
      cur_n.lvl  = req_lvl;
      cur_n.rset = req_set;
      take_irq   = 1'b1;
    end else if (exc_valid) begin
      sav_n      = cur;
      cur_n.ie   = 1'b0;
      cur_n.rset = '0;
      take_exc   = 1'b1;
      take_set   = '0;
      take_addr  = EXC_ADDR;
    end else if (mask_ok) begin
      sav_n      = cur;
      cur_n.ie   = 1'b0;
      cur_n.lvl  = req_lvl;
      cur_n.rset = req_set;
      take_irq   = 1'b1;
    end else if (sw_wr) begin
      cur_n.ie  = sw_ie;
      cur_n.pre = sw_pre;
    end
  end
endmodule

// File: rtl/shirq_status.sv
module shirq_status
  import shirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  eret,
  input  stat_t cur_n,
  input  stat_t sav_n,
  output stat_t cur,
  output stat_t sav
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      sav <= '0;
    end else begin
      cur <= cur_n;
      sav <= sav_n;
    end
  end

  assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
    eret |=> (cur == $past(sav)));
endmodule

// File: rtl/shirq_pulse.sv
module shirq_pulse
  import shirq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_irq,
  input  logic              take_exc,
  input  logic [SET_W-1:0]  take_set,
  input  logic [ADDR_W-1:0] take_addr,
  output logic              acc_irq,
  output logic              acc_exc,
  output logic [SET_W-1:0]  acc_set,
  output logic [ADDR_W-1:0] acc_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_irq  <= 1'b0;
      acc_exc  <= 1'b0;
      acc_set  <= '0;
      acc_addr <= '0;
    end else begin
      acc_irq <= take_irq;
      acc_exc <= take_exc;
      if (take_irq || take_exc) begin
        acc_set  <= take_set;
        acc_addr <= take_addr;
      end
    end
  end

  assert_one_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_irq, acc_exc}));
endmodule

// File: rtl/shadow_irq_gate.sv
module shadow_irq_gate
  import shirq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] EXC_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_nmi,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [SET_W-1:0]  req_set,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              exc_valid,
  input  logic              eret,
  input  logic              sw_wr,
  input  logic              sw_ie,
  input  logic              sw_pre,
  output logic              acc_irq,
  output logic              acc_exc,
  output logic [SET_W-1:0]  acc_set,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              cur_ie,
  output logic [LVL_W-1:0]  cur_lvl,
  output logic [SET_W-1:0]  cur_set,
  output logic              cur_pre,
  output logic              sav_ie,
  output logic [LVL_W-1:0]  sav_lvl,
  output logic [SET_W-1:0]  sav_set,
  output logic              sav_pre
);
  stat_t             cur, sav, cur_n, sav_n;
  logic              take_irq, take_exc;
  logic [SET_W-1:0]  take_set;
  logic [ADDR_W-1:0] take_addr;

  shirq_decide #(.ADDR_W(ADDR_W), .EXC_ADDR(EXC_ADDR)) u_decide (
    .cur(cur), .sav(sav), .eret(eret),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_lvl(req_lvl),
    .req_set(req_set), .req_addr(req_addr), .exc_valid(exc_valid),
    .sw_wr(sw_wr), .sw_ie(sw_ie), .sw_pre(sw_pre),
    .cur_n(cur_n), .sav_n(sav_n), .take_irq(take_irq), .take_exc(take_exc),
    .take_set(take_set), .take_addr(take_addr)
  );

  shirq_status u_status (
    .clk(clk), .rst(rst), .eret(eret),
    .cur_n(cur_n), .sav_n(sav_n), .cur(cur), .sav(sav)
  );

  shirq_pulse #(.ADDR_W(ADDR_W)) u_pulse (
    .clk(clk), .rst(rst), .take_irq(take_irq), .take_exc(take_exc),
    .take_set(take_set), .take_addr(take_addr),
    .acc_irq(acc_irq), .acc_exc(acc_exc), .acc_set(acc_set), .acc_addr(acc_addr)
  );

  assign cur_ie  = cur.ie;
  assign cur_lvl = cur.lvl;
  assign cur_set = cur.rset;
  assign cur_pre = cur.pre;
  assign sav_ie  = sav.ie;
  assign sav_lvl = sav.lvl;
  assign sav_set = sav.rset;
  assign sav_pre = sav.pre;

  assert_no_same_set_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_nmi && !exc_valid && !eret && !cur_pre && req_set == cur_set)
    |=> !acc_irq);

  assert_masked_off_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_nmi && !exc_valid && !eret && (!cur_ie || req_lvl == '0))
    |=> !acc_irq);

  assert_entry_state_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_irq || acc_exc) |-> !cur_ie);

  assert_nmi_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_nmi && !eret) |=> (acc_irq && cur_set == $past(req_set)));

  assert_exc_normal_set_R10: assert property (@(posedge clk) disable iff (rst)
    acc_exc |-> (cur_set == '0 && acc_set == '0));
endmodule

// File: tb/sim_shadow_irq_gate.sv
`timescale 1ns/1ps
module sim_shadow_irq_gate;
  localparam logic [31:0] EXC_A = 32'h20;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_nmi = 0, exc_valid = 0, eret = 0, sw_wr = 0, sw_ie = 0, sw_pre = 0;
  logic [5:0] req_lvl = 0, req_set = 0;
  logic [31:0] req_addr = 0;
  logic acc_irq, acc_exc, cur_ie, cur_pre, sav_ie, sav_pre;
  logic [5:0] acc_set, cur_lvl, cur_set, sav_lvl, sav_set;
  logic [31:0] acc_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic m_ie, m_pre, s_ie, s_pre, m_airq, m_aexc;
  logic [5:0] m_lvl, m_set, s_lvl, s_set, m_aset;
  logic [31:0] m_aaddr;

  always #2.5 clk = ~clk;

  shadow_irq_gate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_nmi(req_nmi),
    .req_lvl(req_lvl), .req_set(req_set), .req_addr(req_addr),
    .exc_valid(exc_valid), .eret(eret), .sw_wr(sw_wr), .sw_ie(sw_ie), .sw_pre(sw_pre),
    .acc_irq(acc_irq), .acc_exc(acc_exc), .acc_set(acc_set), .acc_addr(acc_addr),
    .cur_ie(cur_ie), .cur_lvl(cur_lvl), .cur_set(cur_set), .cur_pre(cur_pre),
    .sav_ie(sav_ie), .sav_lvl(sav_lvl), .sav_set(sav_set), .sav_pre(sav_pre)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mask_ok(input logic v, n, ie, pre, input logic [5:0] l, s, cl, cs);
    return v && !n && ie && l != 0 && l > cl && (s != cs || pre);
  endfunction

  function automatic string path_tag(input logic er, v, n, ex, w, mk, ie, pre, input logic [5:0] s, cs);
    if (er) return "R9";
    if (v && n) return "R7";
    if (ex) return "R10";
    if (mk) return (s == cs) ? "R3" : "R4";
    if (v && !n && !ie) return "R5";
    if (v && !n && s == cs && !pre) return "R2";
    if (v && !n) return "R3";
    if (w) return "R11";
    return "R6";
  endfunction

  task automatic step(input logic er, ex, v, n, input logic [5:0] l, s, input logic [31:0] a,
                      input logic w, wi, wp);
    string tg;
    bit mk;
    eret = er; exc_valid = ex; req_valid = v; req_nmi = n; req_lvl = l; req_set = s;
    req_addr = a; sw_wr = w; sw_ie = wi; sw_pre = wp;
    mk = mask_ok(v, n, m_ie, m_pre, l, s, m_lvl, m_set);
    tg = path_tag(er, v, n, ex, w, mk, m_ie, m_pre, s, m_set);
    m_airq = 0; m_aexc = 0;
    if (er) begin
      m_ie = s_ie; m_lvl = s_lvl; m_set = s_set; m_pre = s_pre;
    end else if ((v && n) || (!ex && mk)) begin
      s_ie = m_ie; s_lvl = m_lvl; s_set = m_set; s_pre = m_pre;
      m_ie = 0; m_lvl = l; m_set = s; m_airq = 1; m_aset = s; m_aaddr = a;
    end else if (ex) begin
      s_ie = m_ie; s_lvl = m_lvl; s_set = m_set; s_pre = m_pre;
      m_ie = 0; m_set = 0; m_aexc = 1; m_aset = 0; m_aaddr = EXC_A;
    end else if (w) begin
      m_ie = wi; m_pre = wp;
    end
    @(negedge clk);
    chk(tg, "acc_irq", acc_irq, m_airq);
    chk(m_aexc ? "R10" : "R6", "acc_exc", acc_exc, m_aexc);
    chk("R6", "acc_set", acc_set, m_aset);
    chk("R6", "acc_addr", acc_addr, m_aaddr);
    chk(tg, "cur_ie", cur_ie, m_ie);
    chk(tg, "cur_lvl", cur_lvl, m_lvl);
    chk(tg, "cur_set", cur_set, m_set);
    chk(tg, "cur_pre", cur_pre, m_pre);
    chk("R8", "sav_ie", sav_ie, s_ie);
    chk("R8", "sav_lvl", sav_lvl, s_lvl);
    chk("R8", "sav_set", sav_set, s_set);
    chk("R8", "sav_pre", sav_pre, s_pre);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_ie = 0; m_pre = 0; s_ie = 0; s_pre = 0; m_lvl = 0; m_set = 0; s_lvl = 0; s_set = 0;
    m_airq = 0; m_aexc = 0; m_aset = 0; m_aaddr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "acc_irq", acc_irq, 0);
    chk("R1", "acc_exc", acc_exc, 0);
    chk("R1", "status", {cur_ie, cur_lvl, cur_set, cur_pre}, 0);
    chk("R1", "saved", {sav_ie, sav_lvl, sav_set, sav_pre}, 0);
    // directed corners
    step(0,0,0,0, 0,0, 0,          1,1,0);  // R11 enable on
    step(0,0,1,0, 3,2, 32'h100,    0,0,0);  // R4 different set accepted
    step(0,0,1,0, 6,4, 32'h104,    0,0,0);  // R5 ie cleared -> refused
    step(0,0,0,0, 0,0, 0,          1,1,0);  // R11
    step(0,0,1,0, 9,2, 32'h108,    0,0,0);  // R2 same set, preempt off
    step(0,0,0,0, 0,0, 0,          1,1,1);  // R11 preempt on
    step(0,0,1,0, 3,2, 32'h10c,    0,0,0);  // R3 equal level refused
    step(0,0,1,0, 5,2, 32'h110,    0,0,0);  // R3 higher level accepted
    step(1,1,1,1, 9,7, 32'h114,    0,0,0);  // R9 eret wins over all
    step(0,0,0,0, 0,0, 0,          1,1,1);  // R11
    step(0,0,1,0, 0,1, 32'h118,    0,0,0);  // R5 level zero ignored
    step(0,0,1,1, 1,3, 32'h11c,    0,0,0);  // R7 nmi with low level
    step(0,0,1,1, 0,3, 32'h120,    0,0,0);  // R7 nmi while ie=0
    step(0,1,1,1, 2,5, 32'h124,    0,0,0);  // R7 nmi beats exception
    step(0,0,0,0, 0,0, 0,          1,1,0);  // R11
    step(0,1,1,0, 40,9, 32'h128,   0,0,0);  // R10 exception beats maskable
    step(1,0,0,0, 0,0, 0,          0,0,0);  // R9 restore
    // random phase
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 16) == 0, ($urandom % 16) == 0, $urandom % 2, ($urandom % 10) == 0,
           6'($urandom % 9), 6'($urandom % 3), $urandom,
           ($urandom % 5) == 0, ($urandom % 4) != 0, $urandom % 2);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule